// File: doc/BRIEF.md
# Divided and Squashed Core Clock Enable Generator

This block derives a slow core-clock enable from a fast input clock. Three stages run in series. A divider takes its ratio from a fixed menu of four values. A squasher walks a programmable bit pattern, one bit per divider pulse: a 1 lets that pulse through and a 0 drops it. A final stage halves whatever pulse rate is left. The result is a one-cycle enable strobe, `strobe_o`, in the input clock domain, not a gated clock. The strobe rate is the input rate divided by the divisor, multiplied by the ratio of one-bits to pattern length, and halved.

Control inputs hold a new divisor select and a new pattern, together with its length. A divisor request waits until a frame-sync strobe, so a running display sees the change at a single, well-defined moment. A pattern request is accepted while the chain runs and takes effect only when the current pattern wraps. Neither a runt nor a doubled pulse is produced. A malformed pattern is refused and raises a sticky error flag. The divider and the squasher can each be bypassed at run time.

Top module: `core_clk_en_chain`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first request takes effect: `strobe_o` = 0, `wave_err_o` = 0, `div_active_o` = 0 (divide by 1), and the active pattern is all ones with length WAVE_W.
- R2: Divisor select encoding: 0 gives divide by 1, 1 gives divide by 1.5 (pulse gaps alternate between 1 and 2 cycles), 2 gives divide by 2, 3 gives divide by 4.
- R3: A divisor request (`div_load_i`) is held pending. It is applied on the clock edge where `frame_sync_i` is high, and `div_active_o` shows the new value from the next cycle on. A request that arrives in the same cycle as a frame sync is applied at once. `div_active_o` never changes without a frame sync.
- R4: The squasher uses pattern bit 0 first and then advances one bit per divider pulse, through `len` bits in total. A 1 passes the pulse and a 0 removes it, so the pass ratio is ones/len.
- R5: The output stage emits one strobe for every second squashed pulse. `strobe_o` is never high in two consecutive cycles.
- R6: Over a long window the strobe count matches input_cycles / divisor × (ones/len) / 2, within ±2.
- R7: A new pattern loaded mid-pattern becomes active only after the last bit of the current pattern has been used.
- R8: A pattern load is refused if the length is 0, if the length exceeds WAVE_W, or if the pattern has no one-bit within its length. A refused load leaves the previous pattern in use and sets `wave_err_o`, which stays set until reset.
- R9: With `div_bypass_i` high the divider passes every cycle, whatever the select. With `sq_bypass_i` high every divider pulse passes the squasher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Requested divisor select |
| div_load_i | input | 1 | Request strobe for a divisor change |
| frame_sync_i | input | 1 | Frame-sync strobe that applies a pending divisor |
| div_bypass_i | input | 1 | Bypass the divider |
| wave_i | input | WAVE_W | Requested squash pattern |
| wave_len_i | input | $clog2(WAVE_W)+1 | Requested pattern length |
| wave_load_i | input | 1 | Request strobe for a pattern change |
| sq_bypass_i | input | 1 | Bypass the squasher |
| strobe_o | output | 1 | Derived single-cycle clock enable |
| div_active_o | output | 2 | Divisor select currently in use |
| wave_err_o | output | 1 | Sticky flag for a refused pattern |

## Verification
The properties assume that the request and sync strobes are synchronous to `clk_i` and that the select and pattern values are stable in the cycle their strobe is high. The bench drives all inputs at the falling edge and keeps each strobe high for one cycle. The rate checks assume the configuration stays fixed for the whole counting window. The bench applies each random configuration, waits longer than one full pattern at the slowest divisor, and only then starts counting.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int unsigned DIV_SEL_W = 2;
  localparam int unsigned DIV_CNT_W = 2;

  typedef enum logic [DIV_SEL_W-1:0] {
    DIV_1   = 2'd0,
    DIV_1P5 = 2'd1,
    DIV_2   = 2'd2,
    DIV_4   = 2'd3
  } div_sel_e;
endpackage

// File: rtl/ccg_div_stage.sv
module ccg_div_stage
  import ccg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bypass_i,
  input  logic [DIV_SEL_W-1:0] sel_i,
  input  logic                 load_i,
  input  logic                 sync_i,
  output logic [DIV_SEL_W-1:0] active_o,
  output logic                 pulse_o
);
  div_sel_e             act_q, pend_q;
  logic                 pend_v_q;
  logic [DIV_CNT_W-1:0] cnt_q, lim;
  logic                 ph_q;
  logic                 hit, apply;

  always_comb begin
    unique case (act_q)
      DIV_1:   lim = DIV_CNT_W'(0);
      DIV_1P5: lim = ph_q ? DIV_CNT_W'(1) : DIV_CNT_W'(0);
      DIV_2:   lim = DIV_CNT_W'(1);
      default: lim = DIV_CNT_W'(3);
    endcase
  end

  assign hit   = (cnt_q == lim);
  assign apply = sync_i && (load_i || pend_v_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= DIV_1;
      pend_q   <= DIV_1;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
      ph_q     <= 1'b0;
    end else begin
      if (load_i) begin
        pend_q   <= div_sel_e'(sel_i);
        pend_v_q <= 1'b1;
      end
      if (apply) begin
        act_q    <= load_i ? div_sel_e'(sel_i) : pend_q;
        pend_v_q <= 1'b0;
        cnt_q    <= '0;
        ph_q     <= 1'b0;
      end else if (hit) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + DIV_CNT_W'(1);
      end
    end
  end

  assign pulse_o  = bypass_i | hit;
  assign active_o = act_q;
endmodule

// File: rtl/ccg_squash_stage.sv
module ccg_squash_stage #(
  parameter int unsigned WAVE_W = 16,
  localparam int unsigned LEN_W = $clog2(WAVE_W) + 1,
  localparam int unsigned PTR_W = $clog2(WAVE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              en_i,
  input  logic [WAVE_W-1:0] wave_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              load_i,
  output logic              en_o,
  output logic              err_o
);
  logic [WAVE_W-1:0] wave_q, pend_wave_q, len_mask;
  logic [LEN_W-1:0]  len_q, pend_len_q, last_idx;
  logic [PTR_W-1:0]  ptr_q;
  logic              pend_v_q, err_q, req_ok, wrap;

  for (genvar gi = 0; gi < WAVE_W; gi++) begin : g_mask
    assign len_mask[gi] = (LEN_W'(gi) < len_i);
  end

  assign req_ok   = (len_i != '0) && (len_i <= LEN_W'(WAVE_W)) && |(wave_i & len_mask);
  assign last_idx = len_q - LEN_W'(1);
  assign wrap     = (LEN_W'(ptr_q) == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q      <= '1;
      len_q       <= LEN_W'(WAVE_W);
      pend_wave_q <= '1;
      pend_len_q  <= LEN_W'(WAVE_W);
      pend_v_q    <= 1'b0;
      ptr_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      if (en_i) begin
        if (wrap) begin
          ptr_q <= '0;
          if (pend_v_q) begin
            wave_q   <= pend_wave_q;
            len_q    <= pend_len_q;
            pend_v_q <= 1'b0;
          end
        end else begin
          ptr_q <= ptr_q + PTR_W'(1);
        end
      end
      // a fresh request overrides the pending one
      if (load_i) begin
        if (req_ok) begin
          pend_wave_q <= wave_i;
          pend_len_q  <= len_i;
          pend_v_q    <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign en_o  = en_i & (bypass_i | wave_q[ptr_q]);
  assign err_o = err_q;
endmodule

// File: rtl/ccg_half_stage.sv
module ccg_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic strobe_o
);
  logic tog_q, str_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      str_q <= 1'b0;
    end else begin
      tog_q <= tog_q ^ en_i;
      str_q <= en_i & tog_q;
    end
  end

  assign strobe_o = str_q;
endmodule

// File: rtl/core_clk_en_chain.sv
module core_clk_en_chain
  import ccg_pkg::*;
#(
  parameter int unsigned WAVE_W = 16,
  localparam int unsigned LEN_W = $clog2(WAVE_W) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 div_load_i,
  input  logic                 frame_sync_i,
  input  logic                 div_bypass_i,
  input  logic [WAVE_W-1:0]    wave_i,
  input  logic [LEN_W-1:0]     wave_len_i,
  input  logic                 wave_load_i,
  input  logic                 sq_bypass_i,
  output logic                 strobe_o,
  output logic [DIV_SEL_W-1:0] div_active_o,
  output logic                 wave_err_o
);
  logic div_pulse, sq_pulse;

  ccg_div_stage u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (div_bypass_i),
    .sel_i    (div_sel_i),
    .load_i   (div_load_i),
    .sync_i   (frame_sync_i),
    .active_o (div_active_o),
    .pulse_o  (div_pulse)
  );

  ccg_squash_stage #(.WAVE_W(WAVE_W)) u_sq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (sq_bypass_i),
    .en_i     (div_pulse),
    .wave_i   (wave_i),
    .len_i    (wave_len_i),
    .load_i   (wave_load_i),
    .en_o     (sq_pulse),
    .err_o    (wave_err_o)
  );

  ccg_half_stage u_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sq_pulse),
    .strobe_o (strobe_o)
  );
endmodule

// File: rtl/ccg_chain_chk.sv
module ccg_chain_chk #(
  parameter int unsigned WAVE_W = 16,
  localparam int unsigned LEN_W = $clog2(WAVE_W) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       div_sel_i,
  input logic             div_load_i,
  input logic             frame_sync_i,
  input logic [LEN_W-1:0] wave_len_i,
  input logic             wave_load_i,
  input logic             strobe_o,
  input logic [1:0]       div_active_o,
  input logic             wave_err_o
);
  a_r5_no_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  a_r3_hold_without_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_i |=> $stable(div_active_o));

  a_r3_same_cycle_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_sync_i && div_load_i) |=> (div_active_o == $past(div_sel_i)));

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_err_o |=> wave_err_o);

  a_r8_zero_len_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_load_i && wave_len_i == '0) |=> wave_err_o);
endmodule

bind core_clk_en_chain ccg_chain_chk #(.WAVE_W(WAVE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .div_sel_i    (div_sel_i),
  .div_load_i   (div_load_i),
  .frame_sync_i (frame_sync_i),
  .wave_len_i   (wave_len_i),
  .wave_load_i  (wave_load_i),
  .strobe_o     (strobe_o),
  .div_active_o (div_active_o),
  .wave_err_o   (wave_err_o)
);

// File: tb/core_clk_en_chain_tb_top.sv
module core_clk_en_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAVE_W = 16;
  localparam int LEN_W = $clog2(WAVE_W) + 1;
  localparam int WIN = 2400;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        div_sel = '0;
  logic              div_load = 1'b0, frame_sync = 1'b0, div_byp = 1'b0;
  logic [WAVE_W-1:0] wave = '1;
  logic [LEN_W-1:0]  wave_len = LEN_W'(WAVE_W);
  logic              wave_load = 1'b0, sq_byp = 1'b0;
  logic              strobe;
  logic [1:0]        div_act;
  logic              werr;

  int checks = 0, failures = 0, adj_hits = 0;
  bit done = 0, prev_strobe = 0, adj_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_clk_en_chain #(.WAVE_W(WAVE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .div_sel_i(div_sel), .div_load_i(div_load),
    .frame_sync_i(frame_sync), .div_bypass_i(div_byp), .wave_i(wave),
    .wave_len_i(wave_len), .wave_load_i(wave_load), .sq_bypass_i(sq_byp),
    .strobe_o(strobe), .div_active_o(div_act), .wave_err_o(werr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones_in(input logic [WAVE_W-1:0] w, input int len);
    int n = 0;
    for (int i = 0; i < len; i++) if (w[i]) n++;
    return n;
  endfunction

  function automatic int div_num(input int sel);
    return (sel == 1) ? 2 : 1;
  endfunction

  function automatic int div_den(input int sel);
    case (sel)
      0: return 1;
      1: return 3;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  // R5 monitor: never two strobes in a row
  always @(negedge clk) begin
    if (adj_on && prev_strobe && strobe) adj_hits++;
    prev_strobe = strobe;
  end

  task automatic count_strobes(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (strobe) n++;
    end
  endtask

  task automatic configure(input int sel, input logic [WAVE_W-1:0] w, input int len,
                           input bit dbyp, input bit sbyp);
    @(negedge clk);
    div_sel = 2'(sel); div_load = 1'b1; frame_sync = 1'b1;
    wave = w; wave_len = LEN_W'(len); wave_load = 1'b1;
    div_byp = dbyp; sq_byp = sbyp;
    @(negedge clk);
    div_load = 1'b0; frame_sync = 1'b0; wave_load = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic rate_check(input int sel, input logic [WAVE_W-1:0] w, input int len,
                            input bit dbyp, input bit sbyp, input string req);
    int n, es, on, num, den, diff;
    es  = dbyp ? 0 : sel;
    on  = sbyp ? len : ones_in(w, len);
    num = WIN * div_num(es) * on;
    den = div_den(es) * len * 2;
    count_strobes(WIN, n);
    diff = n * den - num;
    if (diff < 0) diff = -diff;
    check(diff <= 2 * den, req, n, num / den);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [WAVE_W-1:0] w;
    int sel, len;
    bit dbyp, sbyp;
    void'($urandom(32'h5eed_1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(strobe == 1'b0, "R1 strobe in reset", strobe, 0);
    check(werr == 1'b0, "R1 err in reset", werr, 0);
    check(div_act == 2'd0, "R1 div_active in reset", div_act, 0);
    rst_ni = 1'b1;
    adj_on = 1;

    // R7: swap requested at cycle 2, old all-ones len-16 pattern runs to its end
    n = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (strobe) n++;
      if (i == 2) begin wave = WAVE_W'(1); wave_len = LEN_W'(2); wave_load = 1'b1; end
      else wave_load = 1'b0;
    end
    check(n == 8, "R7 old pattern kept until wrap", n, 8);
    count_strobes(32, n);
    check(n == 8, "R7 new pattern after wrap", n, 8);
    check(werr == 1'b0, "R1 no error after valid load", werr, 0);

    // R3: deferred divisor
    @(negedge clk); div_sel = 2'd3; div_load = 1'b1;
    @(negedge clk); div_load = 1'b0;
    repeat (5) @(negedge clk);
    check(div_act == 2'd0, "R3 pending not applied", div_act, 0);
    frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    check(div_act == 2'd3, "R3 applied at frame sync", div_act, 3);
    frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    check(div_act == 2'd3, "R3 sync without request keeps value", div_act, 3);
    div_sel = 2'd2; div_load = 1'b1; frame_sync = 1'b1;
    @(negedge clk); div_load = 1'b0; frame_sync = 1'b0;
    check(div_act == 2'd2, "R3 same-cycle request applied", div_act, 2);

    // R2 / R4: each divisor with a plain all-ones pattern, then squashed patterns
    for (int s = 0; s < 4; s++) begin
      configure(s, '1, WAVE_W, 0, 0);
      rate_check(s, '1, WAVE_W, 0, 0, $sformatf("R2 divisor sel=%0d", s));
    end
    configure(0, 16'h0005, 4, 0, 0);
    rate_check(0, 16'h0005, 4, 0, 0, "R4 pattern 0101 len 4");
    configure(1, 16'h0001, 16, 0, 0);
    rate_check(1, 16'h0001, 16, 0, 0, "R4 single one len 16");
    configure(0, 16'h0001, 1, 0, 0);
    rate_check(0, 16'h0001, 1, 0, 0, "R5 len 1 max rate");

    // R9: bypasses
    configure(3, '1, WAVE_W, 1, 0);
    rate_check(3, '1, WAVE_W, 1, 0, "R9 divider bypass");
    configure(2, 16'h0001, 16, 0, 1);
    rate_check(2, 16'h0001, 16, 0, 1, "R9 squash bypass");

    // R8: refused loads keep the 0x0007/len 8 pattern
    configure(0, 16'h0007, 8, 0, 0);
    check(werr == 1'b0, "R8 no error before bad load", werr, 0);
    @(negedge clk); wave = '1; wave_len = '0; wave_load = 1'b1;
    @(negedge clk); wave_load = 1'b0;
    check(werr == 1'b1, "R8 zero length refused", werr, 1);
    @(negedge clk); wave = '0; wave_len = LEN_W'(4); wave_load = 1'b1;
    @(negedge clk); wave = 16'hFFF0; wave_len = LEN_W'(4);
    @(negedge clk); wave = '1; wave_len = LEN_W'(WAVE_W + 1);
    @(negedge clk); wave_load = 1'b0;
    repeat (40) @(negedge clk);
    rate_check(0, 16'h0007, 8, 0, 0, "R8 old pattern retained");
    check(werr == 1'b1, "R8 error sticky", werr, 1);

    // R6: random configurations
    for (int k = 0; k < 24; k++) begin
      sel  = int'($urandom_range(3, 0));
      len  = int'($urandom_range(WAVE_W, 1));
      w    = WAVE_W'($urandom);
      if (ones_in(w, len) == 0) w[0] = 1'b1;
      dbyp = ($urandom_range(7, 0) == 0);
      sbyp = ($urandom_range(7, 0) == 0);
      configure(sel, w, len, dbyp, sbyp);
      rate_check(sel, w, len, dbyp, sbyp, $sformatf("R6 random cfg %0d", k));
    end

    check(adj_hits == 0, "R5 adjacent strobes", adj_hits, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule